// File: doc/BRIEF.md
# Serially Loaded Cartridge Bank Controller

This block turns CPU writes into bank numbers for a game cartridge. The CPU loads its registers through a one-bit serial port. Any write into the upper 32 KB of the CPU address space shifts data bit 0 into a 5-bit shift register. On the fifth accepted write, the assembled value is committed to one of four registers: control, pattern bank A, pattern bank B or program bank. Address bits 14:13 of that fifth write pick the register. A write with data bit 7 set restarts the serial sequence. A write on the cycle right after an accepted write is dropped, so a read-modify-write instruction that writes twice counts only once.

From its registers the block drives five outputs. Two are 16 KB program bank indices, one for CPU window 0x8000 and one for CPU window 0xC000. Two are 4 KB pattern bank indices, one for PPU 0x0000 and one for PPU 0x1000. The last is a 2-bit nametable mirroring code. The memory arrays sit outside the block. They join these bank indices with the low address bits.

The clock runs at one tick per CPU cycle. `cpu_wr` is high for each cycle that holds a CPU write.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset the control register holds 0x0C and the other registers hold 0. The outputs are then: program window 0x8000 = bank 0, program window 0xC000 = bank 15, pattern windows = banks 0 and 1, mirroring = 0.
- R2: A write whose address has bit 15 clear changes no register and does not advance the serial sequence. This holds even when its data has bit 7 set.
- R3: An accepted write with data bit 7 set clears the shift register and the write counter, and ORs 0x0C into the control register. The mirroring bits and the pattern-mode bit keep their values.
- R4: A write in the cycle right after an accepted write is ignored. This holds even when that write has data bit 7 set.
- R5: Accepted writes shift in data bit 0, least significant bit first. On the fifth write the value is committed. Address bits 14:13 select the target: 0 = control, 1 = pattern bank A, 2 = pattern bank B, 3 = program bank. The counter then restarts at zero.
- R6: The mirroring output equals control bits 1:0.
- R7: When control bits 3:2 are 0 or 1, window 0x8000 gets the program value with bit 0 cleared, and window 0xC000 gets that value with bit 0 set.
- R8: When control bits 3:2 are 2, window 0x8000 is fixed at bank 0 and window 0xC000 gets the 4-bit program value.
- R9: When control bits 3:2 are 3, window 0x8000 gets the 4-bit program value and window 0xC000 is fixed at bank 15 (the last bank of a 256 KB half).
- R10: When control bit 4 is 0, the pattern windows get pattern bank A with bit 0 cleared, and then with bit 0 set. When control bit 4 is 1, PPU 0x0000 gets pattern bank A and PPU 0x1000 gets pattern bank B.
- R11: Bit 4 of pattern bank A adds 16 to both program window indices. This selects the upper 256 KB half of program ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | CPU write in this cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| prg_bank_lo | output | PRG_W | 16 KB bank index for CPU window 0x8000 |
| prg_bank_hi | output | PRG_W | 16 KB bank index for CPU window 0xC000 |
| chr_bank_lo | output | CHR_W | 4 KB bank index for PPU window 0x0000 |
| chr_bank_hi | output | CHR_W | 4 KB bank index for PPU window 0x1000 |
| mirror | output | 2 | Nametable mirroring code |

## Verification
The assertions assume that `cpu_wr`, `cpu_addr` and `cpu_data` are stable for a whole clock cycle. They also assume that a write lasting two cycles really is two CPU writes, so the drop rule applies to it. The bench changes inputs only at falling edges. It leaves an idle cycle after each write, except where it deliberately issues two writes in a row. The mapping checks assume the default 32-bank program ROM. The sweeps cover every program value in every mode and both halves, and every value of pattern bank A in both pattern modes.

// File: rtl/bank_ctrl_pkg.sv
package bank_ctrl_pkg;

    localparam int SER_BITS = 5;

    typedef enum logic [1:0] {
        PM_WIDE0  = 2'd0,
        PM_WIDE1  = 2'd1,
        PM_FIXLOW = 2'd2,
        PM_FIXTOP = 2'd3
    } prg_mode_e;

    typedef enum logic [1:0] {
        TGT_CTRL = 2'd0,
        TGT_PATA = 2'd1,
        TGT_PATB = 2'd2,
        TGT_PRG  = 2'd3
    } target_e;

    typedef struct packed {
        logic [2:0]          cnt;
        logic [SER_BITS-1:0] shr;
        logic [SER_BITS-1:0] ctrl;
        logic [SER_BITS-1:0] pat_a;
        logic [SER_BITS-1:0] pat_b;
        logic [3:0]          prg;
        logic                busy;
    } loader_t;

endpackage

// File: rtl/bank_serial_loader.sv
module bank_serial_loader
    import bank_ctrl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [15:0]         addr,
    input  logic [7:0]          data,
    output logic [SER_BITS-1:0] ctrl,
    output logic [SER_BITS-1:0] pat_a,
    output logic [SER_BITS-1:0] pat_b,
    output logic [3:0]          prg
);

    localparam logic [2:0] LAST_CNT = 3'(SER_BITS - 1);

    loader_t             st_d, st_q;
    logic                accept;
    logic [SER_BITS-1:0] shifted;
    logic                addr_unused;
    logic                data_unused;

    assign addr_unused = ^{addr[12:0]};
    assign data_unused = ^{data[6:1]};

    always_comb begin
        st_d    = st_q;
        accept  = wr_en && addr[15] && !st_q.busy;
        shifted = {data[0], st_q.shr[SER_BITS-1:1]};
        st_d.busy = accept;
        if (accept) begin
            if (data[7]) begin
                st_d.cnt  = '0;
                st_d.shr  = '0;
                st_d.ctrl = st_q.ctrl | 5'b01100;
            end else if (st_q.cnt == LAST_CNT) begin
                st_d.cnt = '0;
                st_d.shr = '0;
                case (target_e'(addr[14:13]))
                    TGT_CTRL: st_d.ctrl  = shifted;
                    TGT_PATA: st_d.pat_a = shifted;
                    TGT_PATB: st_d.pat_b = shifted;
                    default:  st_d.prg   = shifted[3:0];
                endcase
            end else begin
                st_d.cnt = st_q.cnt + 3'd1;
                st_d.shr = shifted;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ctrl <= 5'b01100;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl  = st_q.ctrl;
    assign pat_a = st_q.pat_a;
    assign pat_b = st_q.pat_b;
    assign prg   = st_q.prg;

    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr[15]) |=> ($stable(st_q.cnt) && $stable(st_q.ctrl) && $stable(st_q.prg))); // R2
    AST_CLEAR_FORCES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && data[7]) |=> (st_q.cnt == 3'd0 && st_q.ctrl[3:2] == 2'b11)); // R3
    AST_DROP_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && wr_en) |=> ($stable(st_q.cnt) && $stable(st_q.shr) && $stable(st_q.ctrl))); // R4
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_CNT); // R5
    AST_COMMIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !data[7] && st_q.cnt == LAST_CNT) |=> (st_q.cnt == 3'd0)); // R5

endmodule

// File: rtl/bank_prg_map.sv
module bank_prg_map
    import bank_ctrl_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int PRG_W     = $clog2(PRG_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [3:0]       sel,
    input  logic             upper_half,
    output logic [PRG_W-1:0] bank_lo,
    output logic [PRG_W-1:0] bank_hi
);

    localparam int         HALF_BANKS = (PRG_BANKS > 16) ? 16 : PRG_BANKS;
    localparam logic [3:0] LAST_IDX   = 4'(HALF_BANKS - 1);

    logic [3:0] lo4, hi4;
    logic [4:0] full_lo, full_hi;

    always_comb begin
        case (prg_mode_e'(mode))
            PM_FIXLOW: begin
                lo4 = 4'd0;
                hi4 = sel;
            end
            PM_FIXTOP: begin
                lo4 = sel;
                hi4 = LAST_IDX;
            end
            default: begin
                lo4 = {sel[3:1], 1'b0};
                hi4 = {sel[3:1], 1'b1};
            end
        endcase
        full_lo = {upper_half, lo4};
        full_hi = {upper_half, hi4};
    end

    assign bank_lo = full_lo[PRG_W-1:0];
    assign bank_hi = full_hi[PRG_W-1:0];

    AST_WIDE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0) |-> (!bank_lo[0] && bank_hi == PRG_W'(bank_lo + 1'b1))); // R7
    AST_LOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> ((int'(bank_lo) % 16) == 0)); // R8
    AST_TOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) == 2'd3 && $stable(upper_half)) |-> $stable(bank_hi)); // R9

endmodule

// File: rtl/bank_chr_map.sv
module bank_chr_map #(
    parameter int CHR_BANKS = 32,
    parameter int CHR_W     = $clog2(CHR_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split,
    input  logic [4:0]       pat_a,
    input  logic [4:0]       pat_b,
    output logic [CHR_W-1:0] bank_lo,
    output logic [CHR_W-1:0] bank_hi
);

    logic [4:0] lo5, hi5;

    always_comb begin
        if (split) begin
            lo5 = pat_a;
            hi5 = pat_b;
        end else begin
            lo5 = {pat_a[4:1], 1'b0};
            hi5 = {pat_a[4:1], 1'b1};
        end
    end

    assign bank_lo = lo5[CHR_W-1:0];
    assign bank_hi = hi5[CHR_W-1:0];

    AST_JOINED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !split |-> (!bank_lo[0] && bank_hi == CHR_W'(bank_lo + 1'b1))); // R10

endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
    import bank_ctrl_pkg::*;
#(
    parameter int PRG_BANKS = 32,
    parameter int CHR_BANKS = 32,
    localparam int PRG_W    = $clog2(PRG_BANKS),
    localparam int CHR_W    = $clog2(CHR_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [15:0]      cpu_addr,
    input  logic [7:0]       cpu_data,
    output logic [PRG_W-1:0] prg_bank_lo,
    output logic [PRG_W-1:0] prg_bank_hi,
    output logic [CHR_W-1:0] chr_bank_lo,
    output logic [CHR_W-1:0] chr_bank_hi,
    output logic [1:0]       mirror
);

    logic [SER_BITS-1:0] ctrl_q, pat_a_q, pat_b_q;
    logic [3:0]          prg_q;

    bank_serial_loader i_loader (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr),
        .addr  (cpu_addr),
        .data  (cpu_data),
        .ctrl  (ctrl_q),
        .pat_a (pat_a_q),
        .pat_b (pat_b_q),
        .prg   (prg_q)
    );

    bank_prg_map #(.PRG_BANKS(PRG_BANKS), .PRG_W(PRG_W)) i_prg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (ctrl_q[3:2]),
        .sel        (prg_q),
        .upper_half (pat_a_q[4]),
        .bank_lo    (prg_bank_lo),
        .bank_hi    (prg_bank_hi)
    );

    bank_chr_map #(.CHR_BANKS(CHR_BANKS), .CHR_W(CHR_W)) i_chr (
        .clk     (clk),
        .rst_n   (rst_n),
        .split   (ctrl_q[4]),
        .pat_a   (pat_a_q),
        .pat_b   (pat_b_q),
        .bank_lo (chr_bank_lo),
        .bank_hi (chr_bank_hi)
    );

    assign mirror = ctrl_q[1:0];

    AST_MIRROR_ONLY_ON_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(mirror)); // R6

endmodule

// File: tb/test_serial_bank_ctrl.sv
module test_serial_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_data = 8'h0;
    logic [4:0]  prg_bank_lo, prg_bank_hi, chr_bank_lo, chr_bank_hi;
    logic [1:0]  mirror;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    serial_bank_ctrl i_serial_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .prg_bank_lo(prg_bank_lo), .prg_bank_hi(prg_bank_hi),
        .chr_bank_lo(chr_bank_lo), .chr_bank_hi(chr_bank_hi), .mirror(mirror)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr2(input logic [15:0] a, input logic [7:0] d1, input logic [7:0] d2);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_data = d1;
        @(negedge clk);
        cpu_data = d2;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] a, input int v);
        for (int i = 0; i < 5; i++) wr1(a, 8'((v >> i) & 1));
    endtask

    function automatic int exp_prg(input int mode, input int sel, input int up, input int top);
        int base = up * 16;
        if (mode < 2) return base + (sel / 2) * 2 + top;
        if (mode == 2) return top ? base + sel : base;
        return top ? base + 15 : base + sel;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 prg lo", prg_bank_lo, 0);
        chk("R1 prg hi", prg_bank_hi, 15);
        chk("R1 chr lo", chr_bank_lo, 0);
        chk("R1 chr hi", chr_bank_hi, 1);
        chk("R1 mirror", mirror, 0);

        for (int m = 0; m < 4; m++) begin
            load(16'h9FFF, 12 | m);
            chk("R6 mirror", mirror, m);
        end

        for (int mode = 0; mode < 4; mode++) begin
            for (int up = 0; up < 2; up++) begin
                load(16'h8000, mode << 2);
                load(16'hA000, up << 4);
                for (int p = 0; p < 16; p++) begin
                    string r;
                    load(16'hE000, p);
                    r = up ? "R11" : (mode < 2 ? "R7" : (mode == 2 ? "R8" : "R9"));
                    chk({r, " prg lo"}, prg_bank_lo, exp_prg(mode, p, up, 0));
                    chk({r, " prg hi"}, prg_bank_hi, exp_prg(mode, p, up, 1));
                end
            end
        end

        for (int s = 0; s < 2; s++) begin
            load(16'h8000, (s << 4) | 12);
            for (int c = 0; c < 32; c++) begin
                load(16'hBFFF, c);
                load(16'hC000, 31 - c);
                chk("R10 chr lo", chr_bank_lo, s ? c : (c / 2) * 2);
                chk("R10 chr hi", chr_bank_hi, s ? 31 - c : (c / 2) * 2 + 1);
            end
        end

        load(16'hA000, 0);
        load(16'h8000, 2);
        load(16'hE000, 6);
        chk("R7 prg lo", prg_bank_lo, 6);
        wr1(16'hE000, 8'h01);
        wr1(16'hE000, 8'h01);
        wr1(16'h8000, 8'h80);
        chk("R3 mirror kept", mirror, 2);
        chk("R3 mode forced lo", prg_bank_lo, 6);
        chk("R3 mode forced hi", prg_bank_hi, 15);
        load(16'hE000, 3);
        chk("R3 counter cleared", prg_bank_lo, 3);

        load(16'h8000, 5'h1C);
        wr1(16'hA000, 8'h80);
        wr1(16'hA000, 8'h01);
        wr1(16'hA000, 8'h01);
        wr1(16'hA000, 8'h01);
        wr1(16'hA000, 8'h00);
        wr1(16'hA000, 8'h00);
        chk("R5 lsb first commit", chr_bank_lo, 7);

        load(16'h8000, 5'h0D);
        wr1(16'hE000, 8'h01);
        wr1(16'h6000, 8'h01);
        wr1(16'h0000, 8'h80);
        wr1(16'h7FFF, 8'h00);
        wr1(16'hE000, 8'h00);
        wr1(16'hE000, 8'h01);
        wr1(16'h4000, 8'h01);
        wr1(16'hE000, 8'h00);
        wr1(16'hE000, 8'h00);
        chk("R2 outside ignored", prg_bank_lo, 5);
        chk("R2 mirror kept", mirror, 1);

        wr2(16'hE000, 8'h00, 8'h80);
        wr2(16'hE000, 8'h01, 8'h00);
        wr2(16'hE000, 8'h00, 8'h01);
        wr2(16'hE000, 8'h01, 8'h00);
        wr2(16'hE000, 8'h00, 8'h01);
        chk("R4 second write dropped", prg_bank_lo, 10);
        chk("R4 mode kept", prg_bank_hi, 15);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule